// File: doc/BRIEF.md
# Remote DMA Data Port with Packet Buffer

This block is the host-facing remote DMA window of a small Ethernet controller. It holds the packet buffer RAM and lets the host move data in and out of it through one data port. The host first loads a 16-bit buffer address and a 16-bit byte count through byte-wide registers. It then reads or writes the data port repeatedly with byte, 16-bit or 32-bit accesses. After every data-port access the address steps forward and the count steps down by the access width. The address folds back to the ring start when it meets the ring stop boundary. When the count reaches zero, a completion bit is raised in the interrupt status register.

The ring start and stop page numbers (256-byte pages) come from the receive logic as inputs. Only the station-address image (the first bytes of the RAM) and the packet window are reachable. Reads outside those areas return all ones, and writes outside them are discarded.

The control is a five-state machine. IDLE accepts a request and moves to REG for any non-data offset, to DRD for a data-port read, to DWR for a data-port write with a nonzero count, or to DROP for a data-port write with a zero count. Each of REG, DRD, DWR and DROP lasts exactly one cycle, asserts the acknowledge, commits its effect on the clock edge that ends it, and returns to IDLE.

Top module: `rdma_port`

## Requirements
- R1: After reset, the address, count, status and mask registers read 0, ack_o is low and irq_o is low.
- R2: A data-port access of size code 0 (byte), 1 (16-bit) or 2/3 (32-bit) adds 1, 2 or 4 to the address and subtracts the same amount from the count. Both wrap modulo 2^16. A read at zero count still transfers and wraps the count.
- R3: The address used for the RAM access is aligned to the access width: bit 0 is cleared for 16-bit accesses and bits 1:0 for 32-bit accesses. The stored address advances from its unaligned value.
- R4: An access is valid when the aligned address is below 32, or at least 1024 and below 3072 (the defaults). An invalid read returns 0xFF, 0xFFFF or 0xFFFFFFFF by width, zero-extended. An invalid write changes no RAM but still advances the address and count.
- R5: Data is little-endian. The byte at the lowest address is on bits 7:0. Byte reads return data in bits 7:0 and 16-bit reads in bits 15:0, with the upper bits zero.
- R6: If the advanced address equals ring stop page × 256, it is replaced by ring start page × 256.
- R7: When an access leaves the count at zero, status bit 6 (offset 0x04) is set.
- R8: A data-port write while the count is zero is ignored: RAM, address, count and status are all unchanged.
- R9: irq_o is the OR of status AND mask (mask at offset 0x05). Writing a one to a status bit clears it.
- R10: Offset 0x1F reads 0 and writes to it have no effect. Unmapped offsets read 0.
- R11: Offsets 0x00/0x01 hold the address low/high byte and 0x02/0x03 hold the count low/high byte. All are written from wdata_i[7:0] and read back in rdata_o[7:0].
- R12: ack_o is high for exactly the one cycle after a request is accepted in IDLE. rdata_o is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access request, sampled in IDLE |
| we_i | input | 1 | 1 = write, 0 = read |
| offset_i | input | 5 | Offset in the device window (0x10 = data port) |
| size_i | input | 2 | Access width code: 0 byte, 1 16-bit, 2/3 32-bit |
| wdata_i | input | 32 | Write data |
| ring_start_i | input | 8 | Ring start page |
| ring_stop_i | input | 8 | Ring stop page |
| ack_o | output | 1 | One-cycle acknowledge |
| rdata_o | output | 32 | Read data, valid with ack_o |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs. The host raises req_i only while no access is in flight, and drops it in the acknowledge cycle. The ring page inputs never change during an access. The ring start page differs from the ring stop page. The bench keeps to all three: every request is a two-cycle task that lowers req_i on seeing ack_o, and the ring pages are only changed between tasks, always to distinct values.

// File: rtl/rdma_port_pkg.sv
package rdma_port_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REG,
        S_DRD,
        S_DWR,
        S_DROP
    } port_state_e;

    localparam logic [4:0] OFF_ADDR_LO = 5'h00;
    localparam logic [4:0] OFF_ADDR_HI = 5'h01;
    localparam logic [4:0] OFF_CNT_LO  = 5'h02;
    localparam logic [4:0] OFF_CNT_HI  = 5'h03;
    localparam logic [4:0] OFF_STATUS  = 5'h04;
    localparam logic [4:0] OFF_MASK    = 5'h05;
    localparam logic [4:0] OFF_DATA    = 5'h10;
    localparam logic [4:0] OFF_RESET   = 5'h1F;

    localparam int DONE_BIT = 6;

    // size code -> byte step
    function automatic logic [2:0] step_of(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/rdma_port_ram.sv
module rdma_port_ram #(
    parameter int WORDS = 768,
    parameter int IDX_W = 14
) (
    input  logic             clk,
    input  logic             we,
    input  logic [3:0]       be,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic             re,
    input  logic [IDX_W-1:0] ridx,
    output logic [31:0]      rdata
);
    localparam int IW = $clog2(WORDS);
    localparam logic [IDX_W:0] WLIM = (IDX_W+1)'(WORDS);

    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we && ({1'b0, widx} < WLIM)) begin
            for (int l = 0; l < 4; l++) begin
                if (be[l]) begin
                    mem[widx[IW-1:0]][l*8 +: 8] <= wdata[l*8 +: 8];
                end
            end
        end
        if (re) begin
            rdata <= ({1'b0, ridx} < WLIM) ? mem[ridx[IW-1:0]] : '1;
        end
    end

endmodule

// File: rtl/rdma_port_lanes.sv
module rdma_port_lanes #(
    parameter int ADDR_W     = 16,
    parameter int MEM_BYTES  = 3072,
    parameter int PMEM_START = 1024,
    parameter int PROM_BYTES = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [31:0]       wdata,
    input  logic [31:0]       ram_q,
    output logic              valid,
    output logic [3:0]        be,
    output logic [31:0]       wword,
    output logic [31:0]       rword
);
    localparam logic [ADDR_W:0] PROM_L = (ADDR_W+1)'(PROM_BYTES);
    localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(PMEM_START);
    localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(MEM_BYTES);

    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W:0]   ax;
    logic [1:0]        lane;
    logic [7:0]        lane_b [4];
    logic [7:0]        b0, b1;

    // per-lane byte view of the RAM word
    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign lane_b[g] = ram_q[g*8 +: 8];
    end

    always_comb begin
        case (size)
            2'd0:    aligned = addr;
            2'd1:    aligned = {addr[ADDR_W-1:1], 1'b0};
            default: aligned = {addr[ADDR_W-1:2], 2'b00};
        endcase
        ax    = {1'b0, aligned};
        lane  = aligned[1:0];
        valid = (ax < PROM_L) || ((ax >= WIN_LO) && (ax < WIN_HI));
        b0    = lane_b[lane];
        b1    = lane_b[{lane[1], 1'b1}];
        case (size)
            2'd0: begin
                be    = 4'b0001 << lane;
                wword = {4{wdata[7:0]}};
                rword = valid ? {24'd0, b0} : 32'h0000_00FF;
            end
            2'd1: begin
                be    = lane[1] ? 4'b1100 : 4'b0011;
                wword = {2{wdata[15:0]}};
                rword = valid ? {16'd0, b1, b0} : 32'h0000_FFFF;
            end
            default: begin
                be    = 4'b1111;
                wword = wdata;
                rword = valid ? ram_q : 32'hFFFF_FFFF;
            end
        endcase
    end

endmodule

// File: rtl/rdma_port_ptr.sv
module rdma_port_ptr #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_reg,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        reg_byte,
    input  logic              advance,
    input  logic [2:0]        step,
    input  logic [7:0]        ring_start,
    input  logic [7:0]        ring_stop,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  cnt,
    output logic              done
);
    localparam int AHI_W = ADDR_W - 8;
    localparam int CHI_W = CNT_W - 8;

    logic [ADDR_W-1:0] start_b, stop_b, addr_inc, addr_nxt;
    logic [CNT_W-1:0]  cnt_nxt;

    always_comb begin
        start_b  = ADDR_W'({ring_start, 8'h00});
        stop_b   = ADDR_W'({ring_stop, 8'h00});
        addr_inc = addr + ADDR_W'(step);
        addr_nxt = (addr_inc == stop_b) ? start_b : addr_inc;
        cnt_nxt  = cnt - CNT_W'(step);
        done     = advance && (cnt_nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            cnt  <= '0;
        end else if (advance) begin
            addr <= addr_nxt;
            cnt  <= cnt_nxt;
        end else if (wr_reg) begin
            case (reg_sel)
                2'd0: addr[7:0]        <= reg_byte;
                2'd1: addr[ADDR_W-1:8] <= reg_byte[AHI_W-1:0];
                2'd2: cnt[7:0]         <= reg_byte;
                default: cnt[CNT_W-1:8] <= reg_byte[CHI_W-1:0];
            endcase
        end
    end

endmodule

// File: rtl/rdma_port.sv
module rdma_port
    import rdma_port_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 16,
    parameter int MEM_BYTES  = 3072,
    parameter int PMEM_START = 1024,
    parameter int PROM_BYTES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        we_i,
    input  logic [4:0]  offset_i,
    input  logic [1:0]  size_i,
    input  logic [31:0] wdata_i,
    input  logic [7:0]  ring_start_i,
    input  logic [7:0]  ring_stop_i,
    output logic        ack_o,
    output logic [31:0] rdata_o,
    output logic        irq_o
);
    localparam int WORDS = MEM_BYTES / 4;
    localparam int IDX_W = ADDR_W - 2;

    port_state_e state_q, state_d;

    logic        op_we;
    logic [4:0]  op_off;
    logic [1:0]  op_size;
    logic [31:0] op_wdata;
    logic [7:0]  isr_q, imr_q;

    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_cnt;
    logic              ptr_done;
    logic [2:0]        step_w;
    logic              dp_rd, dp_wr, dp_drop, reg_wr, ptr_reg_wr;
    logic              ram_re, ram_we, acc_valid;
    logic [3:0]        acc_be;
    logic [31:0]       ram_q, acc_wword, acc_rword;
    logic [7:0]        reg_rd;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = S_IDLE;
        unique case (state_q)
            S_IDLE: begin
                if (req_i) begin
                    if (offset_i != OFF_DATA) state_d = S_REG;
                    else if (!we_i)           state_d = S_DRD;
                    else if (cur_cnt == '0)   state_d = S_DROP;
                    else                      state_d = S_DWR;
                end
            end
            S_REG, S_DRD, S_DWR, S_DROP: state_d = S_IDLE;
        endcase
    end

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_we    <= 1'b0;
            op_off   <= '0;
            op_size  <= '0;
            op_wdata <= '0;
        end else if (state_q == S_IDLE && req_i) begin
            op_we    <= we_i;
            op_off   <= offset_i;
            op_size  <= size_i;
            op_wdata <= wdata_i;
        end
    end

    // state decodes and datapath controls
    always_comb begin
        dp_rd      = (state_q == S_DRD);
        dp_wr      = (state_q == S_DWR);
        dp_drop    = (state_q == S_DROP);
        reg_wr     = (state_q == S_REG) && op_we;
        ptr_reg_wr = reg_wr && (op_off[4:2] == 3'b000);
        step_w     = step_of(op_size);
        ram_re     = (state_q == S_IDLE) && req_i && !we_i && (offset_i == OFF_DATA);
        ram_we     = dp_wr && acc_valid;
    end

    rdma_port_ram #(.WORDS(WORDS), .IDX_W(IDX_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .be    (acc_be),
        .widx  (cur_addr[ADDR_W-1:2]),
        .wdata (acc_wword),
        .re    (ram_re),
        .ridx  (cur_addr[ADDR_W-1:2]),
        .rdata (ram_q)
    );

    rdma_port_lanes #(
        .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES),
        .PMEM_START(PMEM_START), .PROM_BYTES(PROM_BYTES)
    ) u_lanes (
        .addr  (cur_addr),
        .size  (op_size),
        .wdata (op_wdata),
        .ram_q (ram_q),
        .valid (acc_valid),
        .be    (acc_be),
        .wword (acc_wword),
        .rword (acc_rword)
    );

    rdma_port_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_reg     (ptr_reg_wr),
        .reg_sel    (op_off[1:0]),
        .reg_byte   (op_wdata[7:0]),
        .advance    (dp_rd || dp_wr),
        .step       (step_w),
        .ring_start (ring_start_i),
        .ring_stop  (ring_stop_i),
        .addr       (cur_addr),
        .cnt        (cur_cnt),
        .done       (ptr_done)
    );

    // interrupt status and mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
            imr_q <= '0;
        end else begin
            if (ptr_done) begin
                isr_q[DONE_BIT] <= 1'b1;
            end else if (reg_wr && op_off == OFF_STATUS) begin
                isr_q <= isr_q & ~op_wdata[7:0];
            end
            if (reg_wr && op_off == OFF_MASK) begin
                imr_q <= op_wdata[7:0];
            end
        end
    end

    // register readback
    always_comb begin
        case (op_off)
            OFF_ADDR_LO: reg_rd = cur_addr[7:0];
            OFF_ADDR_HI: reg_rd = 8'(cur_addr >> 8);
            OFF_CNT_LO:  reg_rd = cur_cnt[7:0];
            OFF_CNT_HI:  reg_rd = 8'(cur_cnt >> 8);
            OFF_STATUS:  reg_rd = isr_q;
            OFF_MASK:    reg_rd = imr_q;
            default:     reg_rd = 8'h00;
        endcase
    end

    // outputs
    always_comb begin
        ack_o   = (state_q != S_IDLE);
        irq_o   = |(isr_q & imr_q);
        rdata_o = 32'd0;
        unique case (state_q)
            S_REG:   rdata_o = op_we ? 32'd0 : {24'd0, reg_rd};
            S_DRD:   rdata_o = acc_rword;
            S_IDLE, S_DWR, S_DROP: rdata_o = 32'd0;
        endcase
    end

endmodule

// File: rtl/rdma_port_checker.sv
module rdma_port_checker #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_o,
    input logic              irq_o,
    input logic [31:0]       rdata_o,
    input logic              dp_rd,
    input logic              dp_wr,
    input logic              dp_drop,
    input logic              acc_valid,
    input logic              ram_we,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [CNT_W-1:0]  cur_cnt,
    input logic [2:0]        step_w,
    input logic [7:0]        ring_start_i,
    input logic [7:0]        ring_stop_i
);
    assert_ack_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_rd || dp_wr) |=> cur_cnt == CNT_W'($past(cur_cnt) - CNT_W'($past(step_w))));

    assert_drop_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dp_drop |-> !ram_we);

    assert_drop_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dp_drop |=> ($stable(cur_addr) && $stable(cur_cnt)));

    assert_no_stop_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((dp_rd || dp_wr) && ring_start_i != ring_stop_i)
            |=> cur_addr != ADDR_W'({$past(ring_stop_i), 8'h00}));

    assert_invalid_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_rd && !acc_valid) |-> rdata_o[7:0] == 8'hFF);

    assert_irq_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(ack_o));

endmodule

bind rdma_port rdma_port_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_o        (ack_o),
    .irq_o        (irq_o),
    .rdata_o      (rdata_o),
    .dp_rd        (dp_rd),
    .dp_wr        (dp_wr),
    .dp_drop      (dp_drop),
    .acc_valid    (acc_valid),
    .ram_we       (ram_we),
    .cur_addr     (cur_addr),
    .cur_cnt      (cur_cnt),
    .step_w       (step_w),
    .ring_start_i (ring_start_i),
    .ring_stop_i  (ring_stop_i)
);

// File: tb/rdma_port_bench.sv
`timescale 1ns/1ps
module rdma_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic [4:0]  offset_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] wdata_i = '0;
    logic [7:0]  ring_start_i = 8'd4;
    logic [7:0]  ring_stop_i = 8'd12;
    logic        ack_o;
    logic [31:0] rdata_o;
    logic        irq_o;

    int n_checks = 0;
    int n_fail   = 0;

    // behavioural reference state
    logic [7:0] m_mem [3072];
    int         m_addr = 0;
    int         m_cnt  = 0;
    logic [7:0] m_isr  = 8'h00;
    logic [7:0] m_imr  = 8'h00;
    int         m_start = 4;
    int         m_stop  = 12;

    always #2 clk = ~clk;

    rdma_port u_rdma_port (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i),
        .offset_i(offset_i), .size_i(size_i), .wdata_i(wdata_i),
        .ring_start_i(ring_start_i), .ring_stop_i(ring_stop_i),
        .ack_o(ack_o), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one complete access; model predicts, then the port is compared each cycle
    task automatic access(input logic we, input logic [4:0] off, input logic [1:0] sz,
                          input logic [31:0] wd, input string tag);
        logic [31:0] exp_rd;
        int stp, al;
        bit ok;
        exp_rd = 32'd0;
        if (off == 5'h10) begin
            if (!(we && m_cnt == 0)) begin
                stp = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
                al  = m_addr - (m_addr % stp);
                ok  = (al < 32) || (al >= 1024 && al < 3072);
                for (int b = 0; b < stp; b++) begin
                    if (we && ok) m_mem[al + b] = wd[8*b +: 8];
                    else if (!we) exp_rd[8*b +: 8] = ok ? m_mem[al + b] : 8'hFF;
                end
                m_addr = (m_addr + stp) % 65536;
                if (m_addr == m_stop * 256) m_addr = m_start * 256;
                m_cnt = (m_cnt - stp + 65536) % 65536;
                if (m_cnt == 0) m_isr[6] = 1'b1;
            end
        end else begin
            case (off)
                5'h00: if (we) m_addr = (m_addr & 32'hFF00) | int'(wd[7:0]); else exp_rd = m_addr & 32'hFF;
                5'h01: if (we) m_addr = (m_addr & 32'h00FF) | (int'(wd[7:0]) << 8); else exp_rd = (m_addr >> 8) & 32'hFF;
                5'h02: if (we) m_cnt = (m_cnt & 32'hFF00) | int'(wd[7:0]); else exp_rd = m_cnt & 32'hFF;
                5'h03: if (we) m_cnt = (m_cnt & 32'h00FF) | (int'(wd[7:0]) << 8); else exp_rd = (m_cnt >> 8) & 32'hFF;
                5'h04: if (we) m_isr = m_isr & ~wd[7:0]; else exp_rd = {24'd0, m_isr};
                5'h05: if (we) m_imr = wd[7:0]; else exp_rd = {24'd0, m_imr};
                default: exp_rd = 32'd0;
            endcase
        end
        req_i = 1'b1; we_i = we; offset_i = off; size_i = sz; wdata_i = wd;
        @(negedge clk);
        chk("R12 ack high", {31'd0, ack_o}, 32'd1);
        if (!we) chk(tag, rdata_o, exp_rd);
        req_i = 1'b0;
        @(negedge clk);
        chk("R12 ack low", {31'd0, ack_o}, 32'd0);
        chk("R9 irq", {31'd0, irq_o}, {31'd0, |(m_isr & m_imr)});
    endtask

    task automatic set_ptr(input logic [15:0] a, input logic [15:0] c);
        access(1'b1, 5'h00, 2'd0, {24'd0, a[7:0]},  "R11");
        access(1'b1, 5'h01, 2'd0, {24'd0, a[15:8]}, "R11");
        access(1'b1, 5'h02, 2'd0, {24'd0, c[7:0]},  "R11");
        access(1'b1, 5'h03, 2'd0, {24'd0, c[15:8]}, "R11");
    endtask

    task automatic set_ring(input int s, input int e);
        m_start = s; m_stop = e;
        ring_start_i = 8'(s); ring_stop_i = 8'(e);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog actual=hung expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ack", {31'd0, ack_o}, 32'd0);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        for (int o = 0; o < 6; o++) access(1'b0, 5'(o), 2'd0, 32'd0, "R1 reg");

        // R2 R5 R7: fill 20 bytes with word writes, completion on the last
        set_ring(4, 16);
        set_ptr(16'h0400, 16'd20);
        access(1'b1, 5'h10, 2'd2, 32'h4433_2211, "R5");
        access(1'b1, 5'h10, 2'd3, 32'h8877_6655, "R2");
        access(1'b1, 5'h10, 2'd2, 32'hCCBB_AA99, "R2");
        access(1'b1, 5'h10, 2'd2, 32'h00FF_EEDD, "R2");
        access(1'b0, 5'h04, 2'd0, 32'd0, "R7 not yet");
        access(1'b1, 5'h10, 2'd2, 32'h1357_9BDF, "R7");
        access(1'b0, 5'h04, 2'd0, 32'd0, "R7 status");
        access(1'b0, 5'h00, 2'd0, 32'd0, "R2 addr lo");

        // R9 mask and write-one-to-clear
        access(1'b1, 5'h05, 2'd0, 32'h40, "R9");
        access(1'b1, 5'h04, 2'd0, 32'h40, "R9");
        access(1'b1, 5'h05, 2'd0, 32'h00, "R9");

        // R5 byte and 16-bit lanes
        set_ptr(16'h0400, 16'd8);
        for (int i = 0; i < 4; i++) access(1'b0, 5'h10, 2'd0, 32'd0, "R5 byte");
        access(1'b0, 5'h10, 2'd1, 32'd0, "R5 half");
        access(1'b0, 5'h10, 2'd1, 32'd0, "R5 half");

        // R3 alignment
        set_ptr(16'h0403, 16'd8);
        access(1'b0, 5'h10, 2'd1, 32'd0, "R3 half");
        access(1'b0, 5'h10, 2'd2, 32'd0, "R3 word");
        access(1'b0, 5'h00, 2'd0, 32'd0, "R3 addr");
        access(1'b1, 5'h04, 2'd0, 32'hFF, "R9");

        // R4 windows
        set_ptr(16'h0100, 16'd12);
        access(1'b0, 5'h10, 2'd2, 32'd0, "R4 word");
        access(1'b0, 5'h10, 2'd0, 32'd0, "R4 byte");
        access(1'b1, 5'h10, 2'd1, 32'hABCD, "R4 drop");
        access(1'b0, 5'h10, 2'd1, 32'd0, "R4 half");
        access(1'b0, 5'h00, 2'd0, 32'd0, "R4 addr");
        set_ptr(16'h0BFC, 16'd8);
        access(1'b1, 5'h10, 2'd2, 32'hCAFE_F00D, "R4 top");
        access(1'b0, 5'h10, 2'd2, 32'd0, "R4 above");
        set_ptr(16'h0BFC, 16'd4);
        access(1'b0, 5'h10, 2'd2, 32'd0, "R4 top");
        set_ptr(16'h0000, 16'd8);
        access(1'b1, 5'h10, 2'd2, 32'h1234_5678, "R4 prom");
        access(1'b1, 5'h10, 2'd2, 32'h9ABC_DEF0, "R4 prom");
        set_ptr(16'h0000, 16'd8);
        access(1'b0, 5'h10, 2'd2, 32'd0, "R4 prom");
        access(1'b0, 5'h10, 2'd1, 32'd0, "R4 prom");

        // R6 ring wrap
        set_ring(4, 5);
        set_ptr(16'h04FC, 16'd8);
        access(1'b1, 5'h10, 2'd2, 32'h0BAD_CAFE, "R6");
        access(1'b0, 5'h00, 2'd0, 32'd0, "R6 addr lo");
        access(1'b0, 5'h01, 2'd0, 32'd0, "R6 addr hi");
        access(1'b1, 5'h10, 2'd2, 32'h5A5A_A5A5, "R6");
        set_ptr(16'h04FC, 16'd8);
        access(1'b0, 5'h10, 2'd2, 32'd0, "R6 read");
        access(1'b0, 5'h10, 2'd2, 32'd0, "R6 read");
        access(1'b1, 5'h04, 2'd0, 32'hFF, "R9");

        // R8 write at zero count is ignored
        set_ptr(16'h0410, 16'd0);
        access(1'b1, 5'h10, 2'd2, 32'hDEAD_BEEF, "R8");
        access(1'b0, 5'h00, 2'd0, 32'd0, "R8 addr");
        access(1'b0, 5'h02, 2'd0, 32'd0, "R8 cnt");
        access(1'b0, 5'h04, 2'd0, 32'd0, "R8 status");
        access(1'b1, 5'h02, 2'd0, 32'd4, "R11");
        access(1'b0, 5'h10, 2'd2, 32'd0, "R8 data");

        // R2 read at zero count and partial step wrap
        set_ptr(16'h0404, 16'd0);
        access(1'b0, 5'h10, 2'd2, 32'd0, "R2 read");
        access(1'b0, 5'h02, 2'd0, 32'd0, "R2 cnt lo");
        access(1'b0, 5'h03, 2'd0, 32'd0, "R2 cnt hi");
        set_ptr(16'h0404, 16'd3);
        access(1'b0, 5'h10, 2'd2, 32'd0, "R2 read");
        access(1'b0, 5'h02, 2'd0, 32'd0, "R2 cnt lo");
        access(1'b0, 5'h04, 2'd0, 32'd0, "R7 none");

        // R10 reset port and unmapped offsets
        access(1'b1, 5'h1F, 2'd0, 32'hFF, "R10");
        access(1'b0, 5'h1F, 2'd0, 32'd0, "R10 read");
        access(1'b0, 5'h07, 2'd0, 32'd0, "R10 unmapped");
        access(1'b0, 5'h12, 2'd2, 32'd0, "R10 unmapped");
        access(1'b0, 5'h00, 2'd0, 32'd0, "R10 addr kept");
        access(1'b0, 5'h02, 2'd0, 32'd0, "R10 cnt kept");

        finish_run();
    end

endmodule